// File: doc/BRIEF.md
# Video Raster Timing and Reference-Word Generator

This block is the timing master for an 8-bit 4:2:2 component video byte stream. A horizontal position counter and a line counter walk either a 525-line or a 625-line raster. From that position it derives the horizontal, vertical-blanking and field flags. The same flags drive three sync outputs and fill the status byte of the reference words. Each line opens with an end-of-active-video word, then carries the horizontal blanking bytes and a start-of-active-video word, and ends with the active samples.

A pixel-request strobe tells the upstream source when to present a luma or chroma byte. The byte on the data input is written into the stream one clock later. On vertically blanked lines the active region carries blanking codes instead, and the strobe stays low. A change of standard takes effect at the next frame boundary only, so a frame is never cut short or stretched.

The active width and both blanking widths are parameters. Their defaults (1440, 268 and 280 clocks) give lines of 1716 and 1728 clocks.

Top module: `vtg_top`

## Requirements
- R1: `std_sel_i`=0 selects 525 lines and `std_sel_i`=1 selects 625 lines. A line is 4 reference clocks, then BLANK_525 or BLANK_625 blanking clocks, then 4 reference clocks, then ACT_CLKS active clocks. The default line length is 1716 or 1728 clocks.
- R2: `std_sel_i` is sampled only as the last clock of a frame ends. After reset the block runs the 525-line raster until its first frame boundary, whatever `std_sel_i` is.
- R3: Line positions 0 to 3 carry the end-of-active word 0xFF, 0x00, 0x00, XY. The four positions just before the active region carry the start-of-active word, in the same byte order.
- R4: XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first. H is 1 in the end-of-active word and 0 in the start-of-active word.
- R5: `h_flag_o` is 1 from the first end-of-active byte to the last blanking byte. It is 0 during the start-of-active word and the active region.
- R6: The field flag F is 1 on lines 1-3 and 266-525 of the 525 raster, and 0 on lines 4-265. In the 625 raster, F is 0 on lines 1-312 and 1 on lines 313-625. It is driven on `f_flag_o`.
- R7: V is 1 on lines 1-19 and 264-282 of the 525 raster. In the 625 raster, V is 1 on lines 1-22, 311-335 and 624-625. It is driven on `v_flag_o`.
- R8: Blanking bytes, and the active bytes of lines with V=1, alternate 0x80 and 0x10. The value 0x80 falls on even line positions.
- R9: On lines with V=0, the byte at active position p is the `pix_data_i` value presented in the clock before. `byte_o` and the three flag outputs are registered and show line position p one clock after the counters reach p.
- R10: `pix_req_o` is combinational from the counters. It is high exactly for the ACT_CLKS active positions of lines with V=0, one clock before those bytes appear on `byte_o`.
- R11: While `rst_ni` is low, `byte_o` is 0x00, the three flags are 0 and `pix_req_o` is 0. After reset the counters start at line 1, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_sel_i | input | 1 | Standard select: 0 = 525 lines, 1 = 625 lines |
| pix_data_i | input | 8 | Active sample byte, taken one clock after `pix_req_o` |
| byte_o | output | 8 | Multiplexed stream: reference words, blanking codes and samples |
| h_flag_o | output | 1 | H flag |
| v_flag_o | output | 1 | V (vertical blanking) flag |
| f_flag_o | output | 1 | F (field) flag |
| pix_req_o | output | 1 | Request for the next active sample |

## Verification
The bench counts rising edges since reset was released. After N edges, `pix_req_o` reflects raster position N, because it is decoded directly from the counters. `byte_o` and the three flags reflect position N-1, because they pass through one register. The sample supplied at position N-1 therefore shows up at that same registered position.

Every check samples at the falling edge, after the count has settled. The expected value is tied to a position computed from the line lengths and line numbers in the requirements. The standard select is moved well inside a frame, so a switch that takes effect early lands on a wrong-length line and shows up in the checks.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} vid_std_e;

  localparam int unsigned LINES_525 = 525;
  localparam int unsigned LINES_625 = 625;
  localparam int unsigned LW        = 10;
  localparam int unsigned REF_CLKS  = 4;

  function automatic logic [7:0] status_word(logic f, logic v, logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic field_of(vid_std_e s, logic [LW-1:0] ln);
    if (s == STD_625) return ln >= LW'(313);
    return (ln < LW'(4)) || (ln >= LW'(266));
  endfunction

  function automatic logic vblank_of(vid_std_e s, logic [LW-1:0] ln);
    if (s == STD_625)
      return (ln <= LW'(22)) || (ln >= LW'(311) && ln <= LW'(335)) || (ln >= LW'(624));
    return (ln <= LW'(19)) || (ln >= LW'(264) && ln <= LW'(282));
  endfunction
endpackage

// File: rtl/vtg_h_cnt.sv
module vtg_h_cnt #(
  parameter int unsigned HW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] line_len_i,
  output logic [HW-1:0] h_cnt_o,
  output logic          eol_o
);
  assign eol_o = (h_cnt_o == line_len_i - HW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    h_cnt_o <= '0;
    else if (eol_o) h_cnt_o <= '0;
    else            h_cnt_o <= h_cnt_o + HW'(1);
  end

  p_hcnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_cnt_o < line_len_i);
  p_hcnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> h_cnt_o == '0);
endmodule

// File: rtl/vtg_v_cnt.sv
module vtg_v_cnt
  import vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eol_i,
  input  vid_std_e      std_sel_i,
  output logic [LW-1:0] line_o,
  output vid_std_e      std_q_o,
  output logic          f_o,
  output logic          v_o
);
  logic [LW-1:0] last_line;
  logic          eof;

  assign last_line = (std_q_o == STD_625) ? LW'(LINES_625) : LW'(LINES_525);
  assign eof       = eol_i && (line_o == last_line);
  assign f_o       = field_of(std_q_o, line_o);
  assign v_o       = vblank_of(std_q_o, line_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o  <= LW'(1);
      std_q_o <= STD_525;
    end else if (eof) begin
      line_o  <= LW'(1);
      std_q_o <= std_sel_i;
    end else if (eol_i) begin
      line_o  <= line_o + LW'(1);
    end
  end

  p_std_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eof |=> $stable(std_q_o));
  p_line_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o >= LW'(1) && line_o <= LW'(LINES_625));
  p_frame_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof |=> line_o == LW'(1));
endmodule

// File: rtl/vtg_fmt.sv
module vtg_fmt
  import vtg_pkg::*;
#(
  parameter int unsigned ACT_CLKS  = 1440,
  parameter int unsigned BLANK_525 = 268,
  parameter int unsigned BLANK_625 = 280,
  parameter int unsigned HW        = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_cnt_i,
  input  vid_std_e      std_q_i,
  input  logic          f_i,
  input  logic          v_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    byte_o,
  output logic          h_flag_o,
  output logic          v_flag_o,
  output logic          f_flag_o,
  output logic          pix_req_o
);
  localparam int unsigned SAV0_525 = REF_CLKS + BLANK_525;
  localparam int unsigned SAV0_625 = REF_CLKS + BLANK_625;

  logic [HW-1:0] sav0, act0, sav_off;
  logic          in_eav, in_sav, in_act, h_now;
  logic [1:0]    widx;
  logic [7:0]    nxt_byte;

  assign sav0    = (std_q_i == STD_625) ? HW'(SAV0_625) : HW'(SAV0_525);
  assign act0    = sav0 + HW'(REF_CLKS);
  assign sav_off = h_cnt_i - sav0;
  assign in_eav  = h_cnt_i < HW'(REF_CLKS);
  assign in_sav  = (h_cnt_i >= sav0) && (h_cnt_i < act0);
  assign in_act  = h_cnt_i >= act0;
  assign h_now   = h_cnt_i < sav0;
  assign widx    = in_eav ? h_cnt_i[1:0] : sav_off[1:0];
  assign pix_req_o = in_act && !v_i;

  always_comb begin
    if (in_eav || in_sav) begin
      unique case (widx)
        2'd0:    nxt_byte = 8'hFF;
        2'd3:    nxt_byte = status_word(f_i, v_i, h_now);
        default: nxt_byte = 8'h00;
      endcase
    end else if (pix_req_o) begin
      nxt_byte = data_i;
    end else begin
      nxt_byte = h_cnt_i[0] ? 8'h10 : 8'h80;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o   <= 8'h00;
      h_flag_o <= 1'b0;
      v_flag_o <= 1'b0;
      f_flag_o <= 1'b0;
    end else begin
      byte_o   <= nxt_byte;
      h_flag_o <= h_now;
      v_flag_o <= v_i;
      f_flag_o <= f_i;
    end
  end

  p_xy_prot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_eav || in_sav) && widx == 2'd3 |=>
      byte_o[7] && byte_o[3] == (byte_o[5] ^ byte_o[4]) &&
      byte_o[0] == (byte_o[6] ^ byte_o[5] ^ byte_o[4]));
  p_eav_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(h_flag_o) |-> byte_o == 8'hFF);
  p_req_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |=> !h_flag_o && !v_flag_o);
  p_blank_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_eav && !in_sav && !pix_req_o |=> byte_o == 8'h80 || byte_o == 8'h10);
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int unsigned ACT_CLKS  = 1440,
  parameter int unsigned BLANK_525 = 268,
  parameter int unsigned BLANK_625 = 280
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       std_sel_i,
  input  logic [7:0] pix_data_i,
  output logic [7:0] byte_o,
  output logic       h_flag_o,
  output logic       v_flag_o,
  output logic       f_flag_o,
  output logic       pix_req_o
);
  localparam int unsigned LEN_525 = 2 * REF_CLKS + BLANK_525 + ACT_CLKS;
  localparam int unsigned LEN_625 = 2 * REF_CLKS + BLANK_625 + ACT_CLKS;
  localparam int unsigned LEN_MAX = (LEN_625 > LEN_525) ? LEN_625 : LEN_525;
  localparam int unsigned HW      = $clog2(LEN_MAX);

  logic [HW-1:0] line_len, h_cnt;
  logic [LW-1:0] line_num;
  logic          eol, f_now, v_now;
  vid_std_e      std_q;

  assign line_len = (std_q == STD_625) ? HW'(LEN_625) : HW'(LEN_525);

  vtg_h_cnt #(.HW(HW)) u_h_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_len_i(line_len),
    .h_cnt_o(h_cnt), .eol_o(eol)
  );

  vtg_v_cnt u_v_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .eol_i(eol),
    .std_sel_i(vid_std_e'(std_sel_i)), .line_o(line_num),
    .std_q_o(std_q), .f_o(f_now), .v_o(v_now)
  );

  vtg_fmt #(
    .ACT_CLKS(ACT_CLKS), .BLANK_525(BLANK_525), .BLANK_625(BLANK_625), .HW(HW)
  ) u_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_cnt_i(h_cnt), .std_q_i(std_q),
    .f_i(f_now), .v_i(v_now), .data_i(pix_data_i), .byte_o(byte_o),
    .h_flag_o(h_flag_o), .v_flag_o(v_flag_o), .f_flag_o(f_flag_o),
    .pix_req_o(pix_req_o)
  );

  initial begin
    p_even_blank_r8: assert ((BLANK_525 % 2 == 0) && (BLANK_625 % 2 == 0) && (ACT_CLKS % 2 == 0));
  end
endmodule

// File: tb/vtg_top_tb_top.sv
module vtg_top_tb_top;
  // Shortened raster: 525 line = 4+8+4+16 = 32 clocks, 625 line = 4+12+4+16 = 36
  localparam int unsigned ACT = 16;
  localparam int unsigned B525 = 8;
  localparam int unsigned B625 = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       std_sel_i = 1'b0;
  logic [7:0] pix_data_i = 8'h00;
  logic [7:0] byte_o;
  logic       h_flag_o, v_flag_o, f_flag_o, pix_req_o;

  int checks = 0;
  int errors = 0;
  int cnt;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vtg_top #(.ACT_CLKS(ACT), .BLANK_525(B525), .BLANK_625(B625)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .std_sel_i(std_sel_i), .pix_data_i(pix_data_i),
    .byte_o(byte_o), .h_flag_o(h_flag_o), .v_flag_o(v_flag_o), .f_flag_o(f_flag_o),
    .pix_req_o(pix_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt <= 0;
    else         cnt <= cnt + 1;

  always @(negedge clk_i) pix_data_i <= cnt[7:0] ^ 8'h5A;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cnt %0d)", tag, act, exp, cnt);
    end
  endtask

  task automatic wait_cnt(int k);
    while (cnt < k) @(negedge clk_i);
  endtask

  // {position index, byte, data flag, F V H, requirement number}
  localparam int NV = 30;
  localparam logic [47:0] VEC [NV] = '{
    {32'd0,     8'hFF, 1'b0, 3'b111, 4'd3},  // R3 EAV opening byte
    {32'd3,     8'hF1, 1'b0, 3'b111, 4'd4},  // R4
    {32'd4,     8'h80, 1'b0, 3'b111, 4'd8},  // R8
    {32'd5,     8'h10, 1'b0, 3'b111, 4'd8},  // R8
    {32'd15,    8'hEC, 1'b0, 3'b110, 4'd4},  // R4 SAV on vblank line, R5
    {32'd16,    8'h80, 1'b0, 3'b110, 4'd8},  // R8 active of V=1 line
    {32'd17,    8'h10, 1'b0, 3'b110, 4'd8},
    {32'd99,    8'hB6, 1'b0, 3'b011, 4'd6},  // R6 line 4
    {32'd591,   8'hAB, 1'b0, 3'b010, 4'd7},  // R7 line 19
    {32'd611,   8'h9D, 1'b0, 3'b001, 4'd7},  // R7 line 20
    {32'd623,   8'h80, 1'b0, 3'b000, 4'd4},  // R4 SAV, R5
    {32'd624,   8'h00, 1'b1, 3'b000, 4'd9},  // R9 first sample
    {32'd8387,  8'h9D, 1'b0, 3'b001, 4'd7},  // R7 line 263
    {32'd8419,  8'hB6, 1'b0, 3'b011, 4'd7},  // R7 line 264
    {32'd8483,  8'hF1, 1'b0, 3'b111, 4'd6},  // R6 line 266
    {32'd9027,  8'hDA, 1'b0, 3'b101, 4'd7},  // R7 line 283
    {32'd9039,  8'hC7, 1'b0, 3'b100, 4'd4},
    {32'd16799, 8'h00, 1'b1, 3'b100, 4'd2},  // R2 525 frame kept full length
    {32'd16800, 8'hFF, 1'b0, 3'b011, 4'd1},  // R1 625 frame starts
    {32'd16803, 8'hB6, 1'b0, 3'b011, 4'd6},
    {32'd17595, 8'h9D, 1'b0, 3'b001, 4'd7},  // R7 625 line 23
    {32'd17612, 8'h00, 1'b1, 3'b000, 4'd9},  // R9
    {32'd27963, 8'hB6, 1'b0, 3'b011, 4'd7},  // R7 625 line 311
    {32'd28035, 8'hF1, 1'b0, 3'b111, 4'd6},  // R6 625 line 313
    {32'd28863, 8'hDA, 1'b0, 3'b101, 4'd7},  // R7 625 line 336
    {32'd39247, 8'hEC, 1'b0, 3'b110, 4'd7},  // R7 625 line 624
    {32'd39299, 8'h10, 1'b0, 3'b110, 4'd8},  // R8 625 line 625 last byte
    {32'd39300, 8'hFF, 1'b0, 3'b111, 4'd2},  // R2 back to 525
    {32'd39303, 8'hF1, 1'b0, 3'b111, 4'd4},
    {32'd39332, 8'hFF, 1'b0, 3'b111, 4'd1}   // R1 525 line length again
  };

  initial begin
    wait (cnt == 200);
    @(negedge clk_i) std_sel_i = 1'b1;
    wait (cnt == 30000);
    @(negedge clk_i) std_sel_i = 1'b0;
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 byte", byte_o, 8'h00);
    chk("R11 flags", {f_flag_o, v_flag_o, h_flag_o}, 3'b000);
    chk("R11 req", pix_req_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int idx;
      logic [7:0] exp_b;
      idx = int'(VEC[i][47:16]);
      wait_cnt(idx + 1);
      exp_b = VEC[i][7] ? (idx[7:0] ^ 8'h5A) : VEC[i][15:8];
      chk($sformatf("R%0d byte @%0d", VEC[i][3:0], idx), byte_o, exp_b);
      chk($sformatf("R%0d FVH @%0d", VEC[i][3:0], idx),
          {f_flag_o, v_flag_o, h_flag_o}, VEC[i][6:4]);
    end

    // R10: line 20 of third frame (525), active positions 39924..39939
    wait_cnt(39908);
    ones = 0;
    for (int k = 0; k < 32; k++) begin
      if (cnt == 39923) chk("R10 req before active", pix_req_o, 1'b0);
      if (cnt == 39924) chk("R10 req first active", pix_req_o, 1'b1);
      if (cnt == 39939) chk("R10 req last active", pix_req_o, 1'b1);
      ones += int'(pix_req_o);
      @(negedge clk_i);
    end
    chk("R10 req line end", pix_req_o, 1'b0);
    chk("R10 req count V=0 line", ones, ACT);
    // R10: vblank line 264 of that frame
    wait_cnt(47716);
    ones = 0;
    for (int k = 0; k < 32; k++) begin
      ones += int'(pix_req_o);
      @(negedge clk_i);
    end
    chk("R10 req count V=1 line", ones, 0);

    // R11 and R2: reset mid-frame with 625 selected
    std_sel_i = 1'b1;
    #2 rst_ni = 1'b0;
    #1;
    chk("R11 byte in reset", byte_o, 8'h00);
    chk("R11 flags in reset", {f_flag_o, v_flag_o, h_flag_o}, 3'b000);
    chk("R11 req in reset", pix_req_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    wait_cnt(1);
    chk("R11 first byte", byte_o, 8'hFF);
    wait_cnt(33);
    chk("R2 525 after reset", byte_o, 8'hFF);
    chk("R2 flags after reset", {f_flag_o, v_flag_o, h_flag_o}, 3'b111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule